// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits in front of an SDRAM command sequencer. It decides, each clock cycle, whether the requested command may go to the memory on the coming edge. The block keeps the open or closed state of each of four banks and the row held open in each one. It also runs a set of per-bank and shared countdown timers. A request is a command code with a bank and a row. The block answers in the same cycle with a grant or a stall. A stalled request leaves all state alone, and the requester holds it steady until it is granted.

All timing limits are parameters given in picoseconds, together with the clock period. At elaboration each limit becomes a whole number of cycles, rounded up. A limit of 20 ns with an 8 ns clock therefore takes 3 cycles. A refresh interval counter raises an urgent flag when the interval has run out. The flag stays high until an AUTO REFRESH is granted.

Top module: `sdram_bank_guard`

## Requirements
- R1: After reset every bank is closed, every timing limit counts as already met, refreshUrgent is low, and the refresh interval counter holds its full length.
- R2: A granted ACTIVE (reqCmd 3'd1) opens the addressed bank, and on the next cycle that bank's openRowFlat slice (bits bank*ROW_W upward) shows the requested row.
- R3: A READ (3'd2) or WRITE (3'd3) to a closed bank is never granted.
- R4: A READ or WRITE is first granted tRCD cycles after the ACTIVE edge of the same bank, so with the default 20 ns at an 8 ns clock it stalls 2 cycles when issued right after the ACTIVE.
- R5: An ACTIVE to a bank that is already open is refused whatever its row, until that bank is precharged.
- R6: An ACTIVE to a bank is granted only once tRC has passed since that bank's previous ACTIVE and tRP has passed since its last closing PRECHARGE.
- R7: Two ACTIVE commands to any banks are at least tRRD cycles apart.
- R8: A refused request raises stall, keeps grant low and changes no bank state.
- R9: A PRECHARGE (3'd4) is always granted. It closes an open bank and starts that bank's tRP timer. On a bank that is already closed it has no effect.
- R10: An AUTO REFRESH (3'd5) is granted only when all banks are closed and every tRP timer has expired.
- R11: refreshUrgent rises tREFI-1 edges after reset or after a granted AUTO REFRESH, and it stays high until the next granted AUTO REFRESH.
- R12: Each cycle count is the parameter in picoseconds divided by the clock period and rounded up, with a minimum of one.
- R13: With reqValid low, or with a NOP (3'd0), nothing changes. grant and stall are both low when reqValid is low, and a NOP is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A command request is present |
| reqCmd | input | 3 | Command code: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH |
| reqBank | input | 2 | Target bank |
| reqRow | input | ROW_W | Row address, used by ACTIVE |
| grant | output | 1 | The request takes effect on the coming edge |
| stall | output | 1 | The request is refused this cycle |
| bankOpen | output | NUM_BANKS | One bit per bank, high while a row is open |
| openRowFlat | output | NUM_BANKS*ROW_W | Open row of each bank, bank 0 in the low bits |
| refreshUrgent | output | 1 | The refresh interval has expired |

## Verification
The bench measures how many cycles each command stalls right after the command it depends on. An off-by-one in a timer load would show up as one stall too many or too few for tRCD, tRC, tRP or tRRD. The bench uses 20 ns and 15 ns limits on an 8 ns clock, which are not whole multiples of the period, so rounding down instead of up would give 2 and 1 cycles where 3 and 2 are expected. It holds an ACTIVE against an open bank, and a READ against a closed one, across several cycles. A design that let one through, or changed the recorded row while stalling, would be caught. It also counts the exact number of edges until the refresh flag rises, and it sends an AUTO REFRESH while banks are open or just after precharge.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmdE;

  // Strobes from control to datapath, one per state-changing action
  typedef struct packed {
    logic actGo;
    logic preGo;
    logic refGo;
  } strobeT;

  // Picoseconds to whole cycles, rounded up, never below one
  function automatic int ceilCycles(input int ps, input int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/sdram_guard_timer.sv
module sdram_guard_timer #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic done
);
  localparam int W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LOADV = W'(CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (load)        cnt <= LOADV;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sdram_guard_dp.sv
module sdram_guard_dp
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int RCD       = 3,
  parameter int RC        = 8,
  parameter int RRD       = 2,
  parameter int RP        = 3,
  parameter int REFI      = 1954
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobeT                       strobe,
  input  logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [ROW_W-1:0]             reqRow,
  output logic [NUM_BANKS-1:0]         bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0]   openRowFlat,
  output logic [NUM_BANKS-1:0]         rcdDone,
  output logic [NUM_BANKS-1:0]         actReady,
  output logic                         rrdDone,
  output logic                         allRpDone,
  output logic                         refreshUrgent
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int REF_W  = (REFI > 1) ? $clog2(REFI) : 1;

  logic [NUM_BANKS-1:0] rcDone;
  logic [NUM_BANKS-1:0] rpDone;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    logic [ROW_W-1:0] rowQ;
    assign sel = (reqBank == BANK_W'(g));

    sdram_guard_timer #(.CYC(RCD)) u_rcd (
      .clk(clk), .rstN(rstN), .load(strobe.actGo && sel), .done(rcdDone[g]));
    sdram_guard_timer #(.CYC(RC)) u_rc (
      .clk(clk), .rstN(rstN), .load(strobe.actGo && sel), .done(rcDone[g]));
    sdram_guard_timer #(.CYC(RP)) u_rp (
      .clk(clk), .rstN(rstN), .load(strobe.preGo && sel), .done(rpDone[g]));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[g] <= 1'b0;
        rowQ        <= '0;
      end else if (strobe.actGo && sel) begin
        bankOpen[g] <= 1'b1;
        rowQ        <= reqRow;
      end else if (strobe.preGo && sel) begin
        bankOpen[g] <= 1'b0;
      end
    end

    assign openRowFlat[g*ROW_W +: ROW_W] = rowQ;
    assign actReady[g] = rcDone[g] && rpDone[g];
  end

  sdram_guard_timer #(.CYC(RRD)) u_rrd (
    .clk(clk), .rstN(rstN), .load(strobe.actGo), .done(rrdDone));

  assign allRpDone = &rpDone;

  logic [REF_W-1:0] refCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              refCnt <= REF_W'(REFI - 1);
    else if (strobe.refGo)  refCnt <= REF_W'(REFI - 1);
    else if (refCnt != '0)  refCnt <= refCnt - 1'b1;
  end

  assign refreshUrgent = (refCnt == '0);
endmodule

// File: rtl/sdram_guard_ctrl.sv
module sdram_guard_ctrl
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                         reqValid,
  input  logic [2:0]                   reqCmd,
  input  logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [NUM_BANKS-1:0]         bankOpen,
  input  logic [NUM_BANKS-1:0]         rcdDone,
  input  logic [NUM_BANKS-1:0]         actReady,
  input  logic                         rrdDone,
  input  logic                         allRpDone,
  output logic                         grant,
  output logic                         stall,
  output strobeT                       strobe
);
  cmdE  cmd;
  logic ok;

  assign cmd = cmdE'(reqCmd);

  always_comb begin
    unique case (cmd)
      CMD_ACT:         ok = !bankOpen[reqBank] && actReady[reqBank] && rrdDone;
      CMD_RD, CMD_WR:  ok = bankOpen[reqBank] && rcdDone[reqBank];
      CMD_REF:         ok = (bankOpen == '0) && allRpDone;
      default:         ok = 1'b1;
    endcase
  end

  assign grant = reqValid && ok;
  assign stall = reqValid && !ok;

  always_comb begin
    strobe.actGo = grant && (cmd == CMD_ACT);
    strobe.preGo = grant && (cmd == CMD_PRE) && bankOpen[reqBank];
    strobe.refGo = grant && (cmd == CMD_REF);
  end
endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int CLK_PS    = 8000,
  parameter int TRCD_PS   = 20000,
  parameter int TRC_PS    = 60000,
  parameter int TRRD_PS   = 15000,
  parameter int TRP_PS    = 20000,
  parameter int TREFI_PS  = 15625000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic [2:0]                   reqCmd,
  input  logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input  logic [ROW_W-1:0]             reqRow,
  output logic                         grant,
  output logic                         stall,
  output logic [NUM_BANKS-1:0]         bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0]   openRowFlat,
  output logic                         refreshUrgent
);
  // R12: limits become whole cycles, rounded up
  localparam int RCD  = ceilCycles(TRCD_PS, CLK_PS);
  localparam int RC   = ceilCycles(TRC_PS, CLK_PS);
  localparam int RRD  = ceilCycles(TRRD_PS, CLK_PS);
  localparam int RP   = ceilCycles(TRP_PS, CLK_PS);
  localparam int REFI = ceilCycles(TREFI_PS, CLK_PS);

  strobeT               strobe;
  logic [NUM_BANKS-1:0] rcdDone;
  logic [NUM_BANKS-1:0] actReady;
  logic                 rrdDone;
  logic                 allRpDone;

  sdram_guard_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .reqValid(reqValid), .reqCmd(reqCmd), .reqBank(reqBank),
    .bankOpen(bankOpen), .rcdDone(rcdDone), .actReady(actReady),
    .rrdDone(rrdDone), .allRpDone(allRpDone),
    .grant(grant), .stall(stall), .strobe(strobe));

  sdram_guard_dp #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .RCD(RCD), .RC(RC),
    .RRD(RRD), .RP(RP), .REFI(REFI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqBank(reqBank),
    .reqRow(reqRow), .bankOpen(bankOpen), .openRowFlat(openRowFlat),
    .rcdDone(rcdDone), .actReady(actReady), .rrdDone(rrdDone),
    .allRpDone(allRpDone), .refreshUrgent(refreshUrgent));
endmodule

// File: rtl/sdram_guard_checker.sv
module sdram_guard_checker
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int CLK_PS    = 8000,
  parameter int TRCD_PS   = 20000,
  parameter int TRRD_PS   = 15000
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         reqValid,
  input logic [2:0]                   reqCmd,
  input logic [$clog2(NUM_BANKS)-1:0] reqBank,
  input logic [ROW_W-1:0]             reqRow,
  input logic                         grant,
  input logic                         stall,
  input logic [NUM_BANKS-1:0]         bankOpen,
  input logic [NUM_BANKS*ROW_W-1:0]   openRowFlat,
  input logic                         refreshUrgent
);
  localparam int RCD = ceilCycles(TRCD_PS, CLK_PS);
  localparam int RRD = ceilCycles(TRRD_PS, CLK_PS);
  localparam int SAT = 1 << 20;

  logic actG, rdwrG, refG;
  assign actG  = grant && (reqCmd == 3'd1);
  assign rdwrG = grant && (reqCmd == 3'd2 || reqCmd == 3'd3);
  assign refG  = grant && (reqCmd == 3'd5);

  int sinceAnyAct;
  int sinceBankAct [NUM_BANKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAnyAct <= SAT;
      for (int i = 0; i < NUM_BANKS; i++) sinceBankAct[i] <= SAT;
    end else begin
      sinceAnyAct <= actG ? 0 : ((sinceAnyAct < SAT) ? sinceAnyAct + 1 : SAT);
      for (int i = 0; i < NUM_BANKS; i++)
        sinceBankAct[i] <= (actG && reqBank == i) ? 0 :
                           ((sinceBankAct[i] < SAT) ? sinceBankAct[i] + 1 : SAT);
    end
  end

  p_grant_xor_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (grant || stall) |-> (reqValid && (grant != stall)));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!grant && !stall));

  p_stall_keeps_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(bankOpen) && $stable(openRowFlat)));

  p_rdwr_needs_open_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdwrG |-> bankOpen[reqBank]);

  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdwrG |-> (sinceBankAct[reqBank] >= RCD - 1));

  p_act_closed_r5: assert property (@(posedge clk) disable iff (!rstN)
    actG |-> !bankOpen[reqBank]);

  p_act_records_row_r2: assert property (@(posedge clk) disable iff (!rstN)
    actG |=> (bankOpen[$past(reqBank)] &&
              openRowFlat[$past(reqBank)*ROW_W +: ROW_W] == $past(reqRow)));

  p_rrd_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    actG |-> (sinceAnyAct >= RRD - 1));

  p_ref_all_closed_r10: assert property (@(posedge clk) disable iff (!rstN)
    refG |-> (bankOpen == '0));

  p_ref_clears_urgent_r11: assert property (@(posedge clk) disable iff (!rstN)
    refG |=> !refreshUrgent);
endmodule

bind sdram_bank_guard sdram_guard_checker #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .CLK_PS(CLK_PS),
  .TRCD_PS(TRCD_PS), .TRRD_PS(TRRD_PS)
) u_chk (.*);

// File: tb/sdram_bank_guard_bench.sv
module sdram_bank_guard_bench;
  localparam int CLK_PERIOD = 8;
  localparam int NB = 4;
  localparam int RW = 12;
  // Expected cycle counts for the default limits on an 8 ns clock
  localparam int EXP_RCD  = 3;     // 20 ns / 8 ns = 2.5 -> 3
  localparam int EXP_RC   = 8;     // 60 ns -> 7.5 -> 8
  localparam int EXP_RRD  = 2;     // 15 ns -> 1.875 -> 2
  localparam int EXP_RP   = 3;     // 20 ns -> 3
  localparam int EXP_REFI = 1954;  // 15625 ns -> 1953.125 -> 1954

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqCmd = 3'd0;
  logic [1:0] reqBank = 2'd0;
  logic [RW-1:0] reqRow = '0;
  logic grant, stall, refreshUrgent;
  logic [NB-1:0] bankOpen;
  logic [NB*RW-1:0] openRowFlat;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_bank_guard u_sdram_bank_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqBank(reqBank), .reqRow(reqRow), .grant(grant), .stall(stall),
    .bankOpen(bankOpen), .openRowFlat(openRowFlat),
    .refreshUrgent(refreshUrgent));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rowOf(input int b);
    return int'(openRowFlat[b*RW +: RW]);
  endfunction

  // Called at a falling edge; returns the number of stalled cycles before grant
  task automatic tryCmd(input logic [2:0] c, input int b, input int r, output int stalls);
    stalls = 0;
    reqValid = 1'b1; reqCmd = c; reqBank = 2'(b); reqRow = RW'(r);
    #1;
    while (!grant && stalls < 40) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    reqValid = 1'b0; reqCmd = 3'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset;
    #1;
    check(bankOpen == '0, "R1 banks closed", int'(bankOpen), 0);
    check(!refreshUrgent, "R1 urgent low", int'(refreshUrgent), 0);
    check(!grant && !stall, "R13 idle outputs", int'({grant, stall}), 0);
  endtask

  task automatic testRefreshExpiry;
    int edges = 0;
    while (!refreshUrgent && edges < 3000) begin
      @(negedge clk); #1;
      edges++;
    end
    check(edges == EXP_REFI - 1, "R11 urgent rise edge", edges, EXP_REFI - 1);
    idle(5); #1;
    check(refreshUrgent, "R11 urgent held", int'(refreshUrgent), 1);
    @(negedge clk);
  endtask

  task automatic testRefreshGrant;
    int s;
    tryCmd(3'd5, 0, 0, s);
    check(s == 0, "R10 refresh granted idle", s, 0);
    #1;
    check(!refreshUrgent, "R11 urgent cleared", int'(refreshUrgent), 0);
    @(negedge clk);
  endtask

  task automatic testReadClosed;
    reqValid = 1'b1; reqCmd = 3'd2; reqBank = 2'd1;
    for (int i = 0; i < 4; i++) begin
      #1;
      check(stall && !grant, "R3 read closed stalls", int'({grant, stall}), 1);
      @(negedge clk);
    end
    #1;
    check(bankOpen == '0, "R8 no state change", int'(bankOpen), 0);
    reqValid = 1'b0; reqCmd = 3'd0;
    @(negedge clk);
  endtask

  task automatic testActRead;
    int s;
    tryCmd(3'd1, 0, 'h123, s);
    check(s == 0, "R1 act after reset", s, 0);
    #1;
    check(bankOpen[0] && rowOf(0) == 'h123, "R2 row recorded", rowOf(0), 'h123);
    @(negedge clk);
    idle(0);
    tryCmd(3'd1, 1, 'h05, s); // keep spacing simple: bank 1 open too
    idle(10);
    tryCmd(3'd1, 2, 'h0AA, s);
    tryCmd(3'd2, 2, 0, s);
    check(s == EXP_RCD - 1, "R4 R12 read after act stalls", s, EXP_RCD - 1);
    tryCmd(3'd3, 2, 0, s);
    check(s == 0, "R4 write once rcd met", s, 0);
    tryCmd(3'd0, 0, 0, s);
    check(s == 0, "R13 nop granted", s, 0);
  endtask

  task automatic testRrd;
    int s;
    idle(12);
    tryCmd(3'd4, 1, 0, s);
    tryCmd(3'd4, 2, 0, s);
    idle(12);
    tryCmd(3'd1, 1, 'h011, s);
    tryCmd(3'd1, 2, 'h022, s);
    check(s == EXP_RRD - 1, "R7 rrd stalls", s, EXP_RRD - 1);
  endtask

  task automatic testActOpen;
    int s;
    idle(12);
    reqValid = 1'b1; reqCmd = 3'd1; reqBank = 2'd1; reqRow = RW'('h7FF);
    for (int i = 0; i < 5; i++) begin
      #1;
      check(stall && !grant, "R5 act to open bank refused", int'({grant, stall}), 1);
      @(negedge clk);
    end
    #1;
    check(rowOf(1) == 'h011, "R8 row unchanged on stall", rowOf(1), 'h011);
    reqValid = 1'b0; reqCmd = 3'd0;
    @(negedge clk);
    tryCmd(3'd4, 1, 0, s);
    #1;
    check(!bankOpen[1], "R9 precharge closes", int'(bankOpen[1]), 0);
    @(negedge clk);
    tryCmd(3'd4, 1, 0, s);
    #1;
    check(s == 0 && !bankOpen[1] && rowOf(1) == 'h011, "R9 precharge closed bank",
          s, 0);
    @(negedge clk);
  endtask

  task automatic testRcRp;
    int s;
    idle(12);
    tryCmd(3'd1, 3, 'h333, s);
    tryCmd(3'd4, 3, 0, s);
    tryCmd(3'd1, 3, 'h334, s);
    check(s == EXP_RC - 2, "R6 rc stalls", s, EXP_RC - 2);
    idle(12);
    tryCmd(3'd4, 3, 0, s);
    tryCmd(3'd1, 3, 'h335, s);
    check(s == EXP_RP - 1, "R6 rp stalls", s, EXP_RP - 1);
    #1;
    check(rowOf(3) == 'h335, "R2 new row after reopen", rowOf(3), 'h335);
    @(negedge clk);
  endtask

  task automatic testRefreshBlocked;
    int s;
    reqValid = 1'b1; reqCmd = 3'd5;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(stall && !grant, "R10 refresh with open bank refused", int'({grant, stall}), 1);
      @(negedge clk);
    end
    reqValid = 1'b0; reqCmd = 3'd0;
    for (int b = 0; b < NB; b++) tryCmd(3'd4, b, 0, s);
    #1;
    check(bankOpen == '0, "R9 all closed", int'(bankOpen), 0);
    @(negedge clk);
    tryCmd(3'd4, 3, 0, s); // closed already: no new tRP
    tryCmd(3'd1, 0, 'h001, s);
    idle(12);
    tryCmd(3'd4, 0, 0, s);
    tryCmd(3'd5, 0, 0, s);
    check(s == EXP_RP - 1, "R10 refresh waits rp", s, EXP_RP - 1);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    testReset();
    testRefreshExpiry();
    testRefreshGrant();
    testReadClosed();
    testActRead();
    testRrd();
    testActOpen();
    testRcRp();
    testRefreshBlocked();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule